// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional 8-bit buses, called A and B. For each direction of transfer it can forward the live value of the opposite bus, or it can drive a copy held in one of two storage registers. One register samples the A bus and the other samples the B bus. Each register has its own capture strobe. Data is never inverted on either path.

Each bus appears at the boundary as three vectors: an input carrying the resolved bus value, an output carrying what the block would drive, and a per-bit output enable. The resolution happens outside the block. The block's output wins wherever its enable is set, and the external driver's value is used elsewhere. The package supplies this rule as a function, so the enclosing logic and the bench resolve the bus the same way.

The capture strobes are asynchronous to the system clock. They are sampled by the system clock, and a low-to-high change is detected by comparing each sample with the one before it. When both directions are enabled in real-time mode, each port drives the value it receives from the other bus. Once the external drivers let go, the two buses keep whatever value they last carried.

Top module: `bus_xcvr_reg`

## Requirements
- R1: With `b_use_store`=0 (live), `b_out` equals `a_in` bit for bit without inversion. With `a_use_store`=0 (live), `a_out` equals `b_in`. Both paths are combinational within the same cycle.
- R2: The A-side storage register loads `a_in` when `cap_a_stb` rises. The first system-clock edge that samples the strobe high is edge k. The register holds the value `a_in` had at edge k+1 from edge k+1 onward, and is unchanged at edge k.
- R3: The B-side storage register loads `b_in` when `cap_b_stb` rises, with the same two-edge timing as R2.
- R4: Register capture does not depend on the source selects or the drive enables. Both registers may capture on the same edge, each taking its own bus value from before that edge.
- R5: With `b_use_store`=1, `b_out` shows the A-side register. With `a_use_store`=1, `a_out` shows the B-side register.
- R6: `b_oe` is all ones when `b_drive_en`=1 (active high) and all zeros otherwise. `a_oe` is all ones when `a_drive_n`=0 (active low) and all zeros otherwise.
- R7: Set both directions to live and enable both ports. Once the buses agree, they keep that value when the external drivers change or release.
- R8: Synchronous active-high `rst` clears both storage registers to zero. It also clears both strobe history stages to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_a_stb | input | 1 | Capture strobe for the A-side register (rising edge) |
| cap_b_stb | input | 1 | Capture strobe for the B-side register (rising edge) |
| b_use_store | input | 1 | Source for the B port: 0 live A, 1 stored A |
| a_use_store | input | 1 | Source for the A port: 0 live B, 1 stored B |
| b_drive_en | input | 1 | Drive enable for the B port, active high |
| a_drive_n | input | 1 | Drive enable for the A port, active low |
| a_in | input | W | Resolved A bus value |
| a_out | output | W | Value offered to the A bus |
| a_oe | output | W | Per-bit enable for `a_out` |
| b_in | input | W | Resolved B bus value |
| b_out | output | W | Value offered to the B bus |
| b_oe | output | W | Per-bit enable for `b_out` |

## Verification
The select and enable paths are combinational, so `a_out`, `b_out`, `a_oe` and `b_oe` follow a control change in the same cycle. In the bench, however, each bus passes through a resolver register that updates once per clock, so a change that travels through both buses needs up to three edges to settle. The bench changes inputs on falling edges and samples three falling edges later in the sweep. A strobe raised before edge k is visible at the outputs only after edge k+1. The bench checks the old value after edge k and the new value after edge k+1.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XW = 8;
  typedef logic [XW-1:0] word_t;

  // Bus resolution: block output where enabled, external value elsewhere.
  function automatic word_t bus_resolve(input word_t blk_out, input word_t blk_oe,
                                        input word_t ext_val);
    return (blk_out & blk_oe) | (ext_val & ~blk_oe);
  endfunction

  // Source pick for one direction: stored copy or live bus.
  function automatic word_t pick_src(input logic use_store, input word_t live,
                                     input word_t stored);
    return use_store ? stored : live;
  endfunction

  // Rising edge from a current and a previous sample.
  function automatic logic rose_now(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  import xcvr_pkg::*;

  logic smp_q;
  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      smp_q  <= strobe;
      hist_q <= smp_q;
    end
  end

  assign rise = rose_now(smp_q, hist_q);

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R4
  AST_RISE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !rise); // R8
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din)); // R2 (A side), R3 (B side)
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> q == '0); // R8
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int W = 8
) (
  input  logic         use_store,
  input  logic         en,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  import xcvr_pkg::*;

  assign dout = pick_src(use_store, live, stored);
  assign oe   = {W{en}};

  always_comb begin
    AST_OE_UNIFORM: assert ($countones(oe) == 0 || $countones(oe) == W); // R6
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = xcvr_pkg::XW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_a_stb,
  input  logic         cap_b_stb,
  input  logic         b_use_store,
  input  logic         a_use_store,
  input  logic         b_drive_en,
  input  logic         a_drive_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  localparam int NDIR = 2;  // index 0: A side store, 1: B side store

  logic [NDIR-1:0] stb;
  logic [NDIR-1:0] cap_pulse;
  logic [W-1:0]    bus_in [NDIR];
  logic [W-1:0]    held   [NDIR];

  assign stb       = {cap_b_stb, cap_a_stb};
  assign bus_in[0] = a_in;
  assign bus_in[1] = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_side
    xcvr_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .strobe (stb[d]),
      .rise   (cap_pulse[d])
    );
    xcvr_store #(.W(W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .load (cap_pulse[d]),
      .din  (bus_in[d]),
      .q    (held[d])
    );
  end

  xcvr_drive #(.W(W)) u_drv_b (
    .use_store (b_use_store),
    .en        (b_drive_en),
    .live      (a_in),
    .stored    (held[0]),
    .dout      (b_out),
    .oe        (b_oe)
  );

  xcvr_drive #(.W(W)) u_drv_a (
    .use_store (a_use_store),
    .en        (~a_drive_n),
    .live      (b_in),
    .stored    (held[1]),
    .dout      (a_out),
    .oe        (a_oe)
  );

  AST_BOTH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (cap_pulse == 2'b11) |=> (held[0] == $past(a_in)) && (held[1] == $past(b_in))); // R4
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  import xcvr_pkg::*;
  localparam int W = XW;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_a_stb = 0, cap_b_stb = 0, b_use_store = 0, a_use_store = 0;
  logic b_drive_en = 0, a_drive_n = 1;
  logic [W-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic [W-1:0] bus_a = '0, bus_b = '0;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  // Bus wires modelled as one register stage of resolution per clock.
  always_ff @(posedge clk) begin
    bus_a <= bus_resolve(a_out, a_oe, ext_a);
    bus_b <= bus_resolve(b_out, b_oe, ext_b);
  end
  assign a_in = bus_a;
  assign b_in = bus_b;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb),
    .b_use_store(b_use_store), .a_use_store(a_use_store),
    .b_drive_en(b_drive_en), .a_drive_n(a_drive_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctl(input logic sb, input logic sa, input logic be, input logic an);
    b_use_store = sb; a_use_store = sa; b_drive_en = be; a_drive_n = an;
  endtask

  localparam logic [W-1:0] RA = 8'hA5, RB = 8'h3C, XA = 8'h96, XB = 8'h69;

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R8: registers cleared, seen through the stored sources
    set_ctl(1, 1, 1, 0);
    step(1);
    chk("R8 b_out stored after reset", b_out, '0);
    chk("R8 a_out stored after reset", a_out, '0);
    chk("R6 b_oe enabled", b_oe, '1);
    chk("R6 a_oe enabled (active low)", a_oe, '1);

    // R2 / R3 timing with both ports disabled
    set_ctl(1, 1, 0, 1);
    ext_a = RA; ext_b = RB;
    step(3);
    chk("R6 b_oe disabled", b_oe, '0);
    chk("R6 a_oe disabled", a_oe, '0);
    cap_a_stb = 1'b1; cap_b_stb = 1'b1;
    step(1);
    chk("R2 not yet loaded at first edge", b_out, '0);
    chk("R3 not yet loaded at first edge", a_out, '0);
    step(1);
    chk("R2 A store loaded at second edge", b_out, RA);
    chk("R3 B store loaded at second edge", a_out, RB);
    cap_a_stb = 1'b0; cap_b_stb = 1'b0;
    step(2);

    // Sweep all select and enable combinations (R1, R5, R6)
    ext_a = XA; ext_b = XB;
    for (int c = 0; c < 16; c++) begin
      logic sb, sa, be, an, ad;
      logic [W-1:0] ea, eb;
      sb = c[0]; sa = c[1]; be = c[2]; an = c[3]; ad = ~an;
      set_ctl(0, 0, 0, 1);
      step(3);
      set_ctl(sb, sa, be, an);
      step(3);
      ea = XA; eb = XB;
      if (ad && sa) ea = RB;
      if (be && sb) eb = RA;
      if (ad && !sa && !be) ea = XB;
      if (be && !sb && !ad) eb = XA;
      if (ad && !sa && be && sb) ea = RA;
      if (be && !sb && ad && sa) eb = RB;
      chk("R6 b_oe sweep", b_oe, be ? '1 : '0);
      chk("R6 a_oe sweep", a_oe, ad ? '1 : '0);
      if (!(ad && be && !sa && !sb)) begin
        chk(sb ? "R5 b_out stored sweep" : "R1 b_out live sweep", b_out, sb ? RA : ea);
        chk(sa ? "R5 a_out stored sweep" : "R1 a_out live sweep", a_out, sa ? RB : eb);
      end
    end

    // R4: both capture together while driving stored data (buses cross over)
    set_ctl(1, 1, 1, 0);
    step(3);
    cap_a_stb = 1'b1; cap_b_stb = 1'b1;
    step(2);
    chk("R4 A store took B-side value", b_out, RB);
    chk("R4 B store took A-side value", a_out, RA);
    cap_a_stb = 1'b0; cap_b_stb = 1'b0;

    // R7: hold by reinforcement
    set_ctl(0, 0, 0, 1);
    ext_a = 8'h5A; ext_b = 8'h00;
    step(3);
    set_ctl(0, 0, 1, 1);
    step(3);
    chk("R1 B follows A", b_out, 8'h5A);
    set_ctl(0, 0, 1, 0);
    step(3);
    ext_a = 8'hFF; ext_b = 8'h11;
    step(5);
    chk("R7 A bus held", a_out, 8'h5A);
    chk("R7 B bus held", b_out, 8'h5A);
    chk("R7 A resolved held", a_in, 8'h5A);
    chk("R7 B resolved held", b_in, 8'h5A);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule